// File: doc/BRIEF.md
# Logic Self-Test Engine

This block runs a complete pseudo-random logic self-test over a set of external scan chains that wrap a combinational core. After a start pulse it seeds a pattern generator and a signature compactor. It then repeats, for a programmed number of patterns, a window of shift cycles followed by one functional capture cycle. While each new pattern shifts in, the response captured by the previous pattern shifts out and is folded into the signature. A final unload-only window compacts the last response. The engine then compares the signature with a golden value supplied at start and reports a single pass/fail result.

Chains whose outputs may carry unknown values can be excluded with a per-chain mask, so that they never disturb the signature. The pattern count, golden signature and mask are all taken at the start pulse. The result then stays on the outputs until the next start.

Top module: `lbist_engine`

## Requirements
- R1: A start pulse in idle clears done and pass on the same clock edge. With N ≥ 1 patterns, done rises exactly N·(L+1)+L+1 clock edges after the start edge, where L is the chain length.
- R2: Scan enable is high for windows of exactly L cycles. Between two consecutive load windows it is low for exactly one capture cycle. A run with N ≥ 1 has N load windows and then one unload window, so there are (N+1)·L enable-high cycles and N+1 high-to-low transitions.
- R3: The pattern source is a 16-bit left-shifting Galois LFSR with feedback mask 0x6801 taken from the MSB. It is seeded with 0xACE1 at start and advances once per load-window cycle. In that cycle, scan-in of chain c equals state bit c·(16/chains) before the advance.
- R4: During the unload window every scan-in bit is 0.
- R5: The signature is a 16-bit Galois register with feedback mask 0xA011, seeded with 0x5A5A at start. In each shift cycle that carries a captured response it becomes ({s[14:0],0} ^ (s[15] ? 0xA011 : 0)) ^ d, where d[c] is the masked scan-out of chain c. The first load window is not compacted.
- R6: A chain whose mask bit (bit c for chain c) is 1 contributes 0 to d, so its output values have no effect on the signature.
- R7: Pass is 1 exactly when the final signature equals the golden value held at start. Pass is never 1 without done.
- R8: Done and pass keep their values until the next start pulse.
- R9: Start pulses and changes to pattern count, golden value or mask while a run is in progress have no effect on its timing or result.
- R10: With a pattern count of 0, done rises one edge after the start edge, and pass is 1 exactly when the golden value equals 0x5A5A.
- R11: After reset, done, pass, scan enable and all scan-in bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| pat_count_i | input | PAT_W | Number of patterns to apply, taken at start |
| golden_sig_i | input | SIG_W | Expected final signature, taken at start |
| xmask_i | input | N_CHAINS | Per-chain output mask, taken at start |
| scan_out_i | input | N_CHAINS | Serial outputs of the scan chains |
| scan_en_o | output | 1 | High to shift the chains, low to capture |
| scan_in_o | output | N_CHAINS | Serial inputs to the scan chains |
| done_o | output | 1 | Run complete, held until next start |
| pass_o | output | 1 | Signature matched golden, valid with done |

## Verification
The shift-in of pattern k and the compaction of the response to pattern k−1 occur in the same cycles. An error in either the generator stepping or the response-present gating therefore mixes into one signature. Multi-pattern runs over every pattern count from 0 to 6 and every mask value provoke this overlap. A bench model of the chains and core drives scan-out, and an independent interleaved reference predicts the signature, which is checked through pass with both matching and mismatching golden values. The scan-in stream is compared cycle by cycle against the generator sequence in each window, so that generator faults are told apart from compactor faults. Masked chains are driven with random values to show that they have no effect.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CAPT,
    ST_UNLOAD,
    ST_CMP
  } lbist_st_e;
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
  parameter int             W     = 16,
  parameter int             N_OUT = 4,
  parameter logic [W-1:0]   POLY  = 16'h6801,
  parameter logic [W-1:0]   SEED  = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [N_OUT-1:0] tap_o
);
  localparam int SPREAD = W / N_OUT;

  logic [W-1:0] state_q, state_d;

  assign state_d = {state_q[W-2:0], 1'b0} ^ (state_q[W-1] ? POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (step_i) state_q <= state_d;
  end

  // spread taps across the register to decorrelate neighbouring chains
  for (genvar c = 0; c < N_OUT; c++) begin : g_tap
    assign tap_o[c] = state_q[c*SPREAD];
  end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int           W    = 16,
  parameter int           N_IN = 4,
  parameter logic [W-1:0] POLY = 16'hA011,
  parameter logic [W-1:0] SEED = 16'h5A5A
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            en_i,
  input  logic [N_IN-1:0] data_i,
  input  logic [N_IN-1:0] mask_i,
  output logic [W-1:0]    sig_o
);
  logic [W-1:0] sig_q, fold, sig_d;

  // x-bounding: masked chain outputs contribute 0
  always_comb begin
    fold = '0;
    for (int c = 0; c < N_IN; c++) begin
      fold[c % W] = fold[c % W] ^ (data_i[c] & ~mask_i[c]);
    end
  end

  assign sig_d = ({sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0)) ^ fold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sig_q <= SEED;
    else if (load_i) sig_q <= SEED;
    else if (en_i)   sig_q <= sig_d;
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PAT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAT_W-1:0] pat_count_i,
  output lbist_st_e        st_o,
  output logic             scan_en_o,
  output logic             seed_o,
  output logic             prpg_step_o,
  output logic             misr_en_o,
  output logic             cmp_o
);
  localparam int              SH_W    = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [SH_W-1:0] SH_LAST = SH_W'(CHAIN_LEN - 1);

  lbist_st_e        st_q;
  logic [SH_W-1:0]  sh_q;
  logic [PAT_W-1:0] pat_q, lim_q;
  logic             resp_q;
  logic             accept;

  assign accept = (st_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      pat_q  <= '0;
      lim_q  <= '0;
      resp_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          lim_q  <= pat_count_i;
          pat_q  <= '0;
          sh_q   <= '0;
          resp_q <= 1'b0;
          st_q   <= (pat_count_i == '0) ? ST_CMP : ST_LOAD;
        end
        ST_LOAD: begin
          if (sh_q == SH_LAST) begin
            sh_q <= '0;
            st_q <= ST_CAPT;
          end else begin
            sh_q <= sh_q + SH_W'(1);
          end
        end
        ST_CAPT: begin
          pat_q  <= pat_q + PAT_W'(1);
          resp_q <= 1'b1;
          st_q   <= ((pat_q + PAT_W'(1)) == lim_q) ? ST_UNLOAD : ST_LOAD;
        end
        ST_UNLOAD: begin
          if (sh_q == SH_LAST) begin
            sh_q <= '0;
            st_q <= ST_CMP;
          end else begin
            sh_q <= sh_q + SH_W'(1);
          end
        end
        ST_CMP:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scan_en_o   = (st_q == ST_LOAD) || (st_q == ST_UNLOAD);
    prpg_step_o = (st_q == ST_LOAD);
    // load window overlaps unload of previous response, if any
    misr_en_o   = ((st_q == ST_LOAD) && resp_q) || (st_q == ST_UNLOAD);
    seed_o      = accept;
    cmp_o       = (st_q == ST_CMP);
  end

  assign st_o = st_q;
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
  import lbist_pkg::*;
#(
  parameter int                N_CHAINS  = 4,
  parameter int                CHAIN_LEN = 8,
  parameter int                PAT_W     = 8,
  parameter int                SIG_W     = 16,
  parameter int                PRPG_W    = 16,
  parameter logic [PRPG_W-1:0] PRPG_POLY = 16'h6801,
  parameter logic [PRPG_W-1:0] PRPG_SEED = 16'hACE1,
  parameter logic [SIG_W-1:0]  MISR_POLY = 16'hA011,
  parameter logic [SIG_W-1:0]  MISR_SEED = 16'h5A5A
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PAT_W-1:0]    pat_count_i,
  input  logic [SIG_W-1:0]    golden_sig_i,
  input  logic [N_CHAINS-1:0] xmask_i,
  input  logic [N_CHAINS-1:0] scan_out_i,
  output logic                scan_en_o,
  output logic [N_CHAINS-1:0] scan_in_o,
  output logic                done_o,
  output logic                pass_o
);
  lbist_st_e           st;
  logic                seed, prpg_step, misr_en, cmp;
  logic [N_CHAINS-1:0] prpg_tap;
  logic [N_CHAINS-1:0] xmask_q;
  logic [SIG_W-1:0]    gold_q, sig;
  logic                done_q, pass_q;

  lbist_seq #(
    .CHAIN_LEN (CHAIN_LEN),
    .PAT_W     (PAT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pat_count_i (pat_count_i),
    .st_o        (st),
    .scan_en_o   (scan_en_o),
    .seed_o      (seed),
    .prpg_step_o (prpg_step),
    .misr_en_o   (misr_en),
    .cmp_o       (cmp)
  );

  lbist_prpg #(
    .W     (PRPG_W),
    .N_OUT (N_CHAINS),
    .POLY  (PRPG_POLY),
    .SEED  (PRPG_SEED)
  ) u_prpg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seed),
    .step_i (prpg_step),
    .tap_o  (prpg_tap)
  );

  lbist_misr #(
    .W    (SIG_W),
    .N_IN (N_CHAINS),
    .POLY (MISR_POLY),
    .SEED (MISR_SEED)
  ) u_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seed),
    .en_i   (misr_en),
    .data_i (scan_out_i),
    .mask_i (xmask_q),
    .sig_o  (sig)
  );

  // configuration is frozen for the whole run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xmask_q <= '0;
      gold_q  <= '0;
    end else if (seed) begin
      xmask_q <= xmask_i;
      gold_q  <= golden_sig_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (seed) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (cmp) begin
      done_q <= 1'b1;
      pass_q <= (sig == gold_q);
    end
  end

  assign scan_in_o = (st == ST_LOAD) ? prpg_tap : '0;
  assign done_o    = done_q;
  assign pass_o    = pass_q;
endmodule

// File: rtl/lbist_engine_chk.sv
module lbist_engine_chk
  import lbist_pkg::*;
#(
  parameter int PAT_W = 8,
  parameter int SIG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [PAT_W-1:0] pat_count_i,
  input logic             scan_en_o,
  input logic             done_o,
  input logic             pass_o,
  input lbist_st_e        st_i,
  input logic [SIG_W-1:0] gold_q_i
);
  // R1
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && start_i) |=> !done_o && !pass_o);

  // R2
  capt_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_CAPT) |=> scan_en_o);

  // R7
  pass_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(pass_o));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_IDLE) |=> $stable(gold_q_i));

  // R10
  zero_pat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && start_i && pat_count_i == '0) |=> st_i == ST_CMP);
endmodule

bind lbist_engine lbist_engine_chk #(
  .PAT_W (PAT_W),
  .SIG_W (SIG_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pat_count_i (pat_count_i),
  .scan_en_o   (scan_en_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .st_i        (st),
  .gold_q_i    (gold_q)
);

// File: tb/tb_lbist_engine.sv
module tb_lbist_engine;
  localparam int NC = 4;
  localparam int CL = 8;
  localparam int PW = 8;
  localparam int SW = 16;
  localparam int T  = NC * CL;
  localparam logic [15:0] P_POLY = 16'h6801, P_SEED = 16'hACE1;
  localparam logic [15:0] M_POLY = 16'hA011, M_SEED = 16'h5A5A;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [PW-1:0] pat_count_i = '0;
  logic [SW-1:0] golden_sig_i = '0;
  logic [NC-1:0] xmask_i = '0;
  logic [NC-1:0] scan_out_i;
  logic          scan_en_o;
  logic [NC-1:0] scan_in_o;
  logic          done_o, pass_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  lbist_engine #(.N_CHAINS(NC), .CHAIN_LEN(CL), .PAT_W(PW), .SIG_W(SW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pat_count_i(pat_count_i),
    .golden_sig_i(golden_sig_i), .xmask_i(xmask_i), .scan_out_i(scan_out_i),
    .scan_en_o(scan_en_o), .scan_in_o(scan_in_o), .done_o(done_o), .pass_o(pass_o)
  );

  // scan chains around a small nonlinear core
  logic [T-1:0]  flat = '0;
  logic [NC-1:0] noise_en = '0;
  logic [NC-1:0] noise = '0;

  function automatic logic [T-1:0] core_f(input logic [T-1:0] f);
    logic [T-1:0] r;
    for (int i = 0; i < T; i++)
      r[i] = f[i] ^ (f[(i+1)%T] & ~f[(i+7)%T]) ^ f[(i+13)%T];
    return r;
  endfunction

  function automatic logic [T-1:0] shift_f(input logic [T-1:0] f, input logic [NC-1:0] sin);
    logic [T-1:0] r;
    for (int c = 0; c < NC; c++) r[c*CL +: CL] = {f[c*CL +: CL-1], sin[c]};
    return r;
  endfunction

  function automatic logic [15:0] prpg_nxt(input logic [15:0] s);
    return {s[14:0], 1'b0} ^ (s[15] ? P_POLY : 16'h0);
  endfunction

  function automatic logic [15:0] misr_nxt(input logic [15:0] s, input logic [NC-1:0] d);
    return ({s[14:0], 1'b0} ^ (s[15] ? M_POLY : 16'h0)) ^ {{(16-NC){1'b0}}, d};
  endfunction

  function automatic logic [NC-1:0] taps(input logic [15:0] s);
    logic [NC-1:0] t;
    for (int c = 0; c < NC; c++) t[c] = s[c*(16/NC)];
    return t;
  endfunction

  // reference: interleaved load / compaction per R3, R5, R6
  function automatic logic [15:0] ref_sig(input int npat, input logic [NC-1:0] mask);
    logic [15:0]   pr = P_SEED;
    logic [15:0]   sg = M_SEED;
    logic [T-1:0]  f  = '0;
    logic [NC-1:0] d, sin;
    if (npat == 0) return M_SEED;
    for (int p = 0; p <= npat; p++) begin
      for (int s = 0; s < CL; s++) begin
        for (int c = 0; c < NC; c++) d[c] = f[c*CL+CL-1] & ~mask[c];
        if (p > 0) sg = misr_nxt(sg, d);
        sin = (p < npat) ? taps(pr) : '0;
        f = shift_f(f, sin);
        if (p < npat) pr = prpg_nxt(pr);
      end
      if (p < npat) f = core_f(f);
    end
    return sg;
  endfunction

  always_ff @(posedge clk) flat <= scan_en_o ? shift_f(flat, scan_in_o) : core_f(flat);
  always @(negedge clk) noise <= NC'($urandom);

  always_comb
    for (int c = 0; c < NC; c++)
      scan_out_i[c] = noise_en[c] ? noise[c] : flat[c*CL+CL-1];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int npat, input logic [NC-1:0] mask, input logic [SW-1:0] golden,
                     input bit exp_pass, input bit disturb);
    int lat = 0, hi = 0, falls = 0, inerr = 0, exp_lat;
    bit prev = 1'b0;
    logic [15:0] pr = P_SEED;
    logic [NC-1:0] expin;
    @(negedge clk);
    pat_count_i = PW'(npat); golden_sig_i = golden; xmask_i = mask; noise_en = mask;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!done_o && !pass_o, "R1", "done/pass cleared by start", {done_o, pass_o}, 0);
    while (!done_o && lat < 5000) begin
      if (scan_en_o) begin
        expin = ((hi / CL) < npat) ? taps(pr) : '0;
        if (scan_in_o != expin) inerr++;
        if ((hi / CL) < npat) pr = prpg_nxt(pr);
        hi++;
      end
      if (prev && !scan_en_o) falls++;
      prev = scan_en_o;
      if (disturb && lat == 5) begin  // R9 stimulus mid-run
        start_i = 1'b1; xmask_i = '0; golden_sig_i = ~golden; pat_count_i = PW'(npat + 1);
      end
      if (disturb && lat == 6) start_i = 1'b0;
      @(negedge clk);
      lat++;
    end
    exp_lat = (npat == 0) ? 1 : npat * (CL + 1) + CL + 1;
    chk(lat == exp_lat, (npat == 0) ? "R10" : (disturb ? "R9" : "R1"), "done latency", lat, exp_lat);
    chk(pass_o == exp_pass, disturb ? "R9" : (mask != 0 ? "R6" : "R7"), "pass result", pass_o, exp_pass);
    chk(hi == ((npat == 0) ? 0 : (npat + 1) * CL), "R2", "enable-high cycles", hi, (npat + 1) * CL);
    chk(falls == ((npat == 0) ? 0 : npat + 1), "R2", "capture transitions", falls, npat + 1);
    chk(inerr == 0, "R3", "scan-in stream mismatches (R4 in unload)", inerr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] e;
    bit p;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11
    chk(!done_o && !pass_o && !scan_en_o && scan_in_o == '0, "R11", "reset outputs",
        {done_o, pass_o, scan_en_o, scan_in_o}, 0);

    // R5 / R7 single and multi pattern, matching and mismatching golden
    e = ref_sig(1, '0); run(1, '0, e, 1'b1, 1'b0);
    run(1, '0, e ^ 16'h0001, 1'b0, 1'b0);
    e = ref_sig(5, '0); run(5, '0, e, 1'b1, 1'b0);
    chk(pass_o, "R5", "five-pattern signature", pass_o, 1);

    // R8 hold
    p = pass_o;
    repeat (25) @(negedge clk);
    chk(done_o && pass_o == p, "R8", "result held while idle", {done_o, pass_o}, {1'b1, p});

    // R6 random values on a masked chain
    e = ref_sig(3, 4'b1000); run(3, 4'b1000, e, 1'b1, 1'b0);
    e = ref_sig(4, 4'b0101); run(4, 4'b0101, e, 1'b1, 1'b0);

    // R9 start and config changes mid-run are ignored
    e = ref_sig(3, 4'b0010); run(3, 4'b0010, e, 1'b1, 1'b1);

    // R10 zero patterns
    run(0, '0, M_SEED, 1'b1, 1'b0);
    run(0, '0, 16'h1234, 1'b0, 1'b0);

    // sweep: every count 0..6 with every mask
    for (int np = 0; np <= 6; np++) begin
      for (int m = 0; m < 16; m++) begin
        bit flip = ((np + m) % 3) == 0;
        e = ref_sig(np, NC'(m));
        run(np, NC'(m), e ^ (flip ? 16'h0010 : 16'h0), !flip, 1'b0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule